// File: doc/BRIEF.md
# Triggered Binary Delay Timer

This block is a synchronous timer/counter built around a start/stop control latch, a gated time base and a binary counter. When it is stopped, every count bit is forced to one, the time base is halted and the time-base monitor rests high. A high level on the trigger input starts the time base. The first time-base tick after the start clears the counter to zero, and every later tick adds one to it. The counter wraps from its maximum back to zero and keeps running until the reset input stops it.

The tick comes from one of two sources, chosen by a select pin. One source is an internal clock-enable divider with a programmable period. The other is an external single-cycle tick. An active-low inhibit pauses counting without clearing the counter.

A select mask picks any subset of the count bits. These bits are ANDed into a combined output, which models open-collector outputs wired together with one pull-up: the combined output is low while any selected bit is low. If the combined output is fed back to the reset input, each trigger gives one low pulse lasting as many time-base periods as the sum of the selected bit weights. If it is not fed back, the block free-runs.

The control interaction is asymmetric. Once the block is running, the trigger input is ignored. A reset request is ignored while the trigger is high, and it takes effect as soon as the trigger falls. Trigger and reset both pass through a two-flop synchronizer before the control latch sees them.

Top module: `tbc_delay_timer`

## Requirements
- R1: While `rst_ni` is low, and from the second cycle after the block stops, `q_o` is all ones and `combo_o` is high (the select mask cannot pull `combo_o` low, because every count bit is one). The block leaves reset in the stopped state.
- R2: A trigger level that is high at clock edge k starts the block at edge k+2 (two synchronizer stages, then the latch). `tb_mon_o` can first go low after edge k+2.
- R3: After a start, `q_o` stays all ones until the first qualified tick. The edge that registers that tick loads zero.
- R4: While the block runs, trigger activity has no effect: the count keeps advancing whatever level or pulses appear on `trig_i`.
- R5: A synchronized reset request with the synchronized trigger low stops the block. A reset level high at edge k stops the block at edge k+2, and `q_o` becomes all ones at edge k+3.
- R6: A reset request is ignored while the synchronized trigger is high. If the request is still high when the trigger falls, the block stops: trigger low at edge k gives stop at edge k+2 and all ones at edge k+3.
- R7: Each qualified tick after the clearing tick adds one to `q_o` at the edge that registers it. `q_o` wraps from all ones to zero and continues.
- R8: `combo_o` is the AND of the `q_o` bits whose `sel_i` bit is set, where bit n of `sel_i` selects bit n of `q_o` (weight 2^n). With an empty mask, `combo_o` is high. When `combo_o` drives the reset input, `combo_o` stays low for (sum of selected weights) × (tick period) cycles.
- R9: While `inhibit_ni` is low, no tick is qualified and `q_o` holds its value. The divider itself is not affected.
- R10: With `tb_ext_sel_i` low, a tick occurs every `div_cfg_i`+1 cycles of running time, the first one `div_cfg_i`+1 cycles after the start. With `tb_ext_sel_i` high, `ext_tick_i` is the tick source, sampled each cycle.
- R11: `tb_mon_o` is low in exactly those cycles where the block runs and the selected source presents a tick, whatever the level of `inhibit_ni`. In every other cycle it is high, and it is always high while the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| trig_i | input | 1 | Start request, level sensitive, asynchronous |
| reset_req_i | input | 1 | Stop request, level sensitive, asynchronous |
| tb_ext_sel_i | input | 1 | 1 selects `ext_tick_i` as the tick source, 0 selects the internal divider |
| ext_tick_i | input | 1 | External single-cycle tick |
| inhibit_ni | input | 1 | Active-low count inhibit |
| div_cfg_i | input | DIV_W | Internal tick period minus one |
| sel_i | input | CNT_W | Mask of the count bits that feed `combo_o` |
| q_o | output | CNT_W | Binary count bits (bit n has weight 2^n) |
| tb_mon_o | output | 1 | Active-low time-base monitor |
| combo_o | output | 1 | AND of the selected count bits |

## Verification
Each result has a fixed latency after its stimulus:
- The tick source, inhibit and mask act combinationally on `tb_mon_o` and `combo_o`, and reach `q_o` at the very next edge.
- Trigger and reset act on the run state two edges after they are sampled, and on `q_o` three edges after they are sampled.
- The first internal tick comes `div_cfg_i`+1 edges after the run state rises.

The bench drives inputs just after the falling edge and samples just before the next falling edge. Its reference model keeps two-entry queues for the synchronized controls, so every output is compared in the cycle where that latency count says it is due. The directed checks step by counted edges that follow the same arithmetic, and they measure one-shot pulse lengths in whole cycles.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  parameter int unsigned TBC_CNT_W = 8;
  parameter int unsigned TBC_DIV_W = 16;
  parameter int unsigned TBC_SYNC_STAGES = 2;

  typedef enum logic [0:0] {
    TBC_STOPPED = 1'b0,
    TBC_RUNNING = 1'b1
  } tbc_state_e;
endpackage

// File: rtl/tbc_sync.sv
module tbc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r <= '0;
        else         r <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r <= '0;
        else         r <= g_stage[s-1].r;
      end
    end
  end

  assign q_o = g_stage[STAGES-1].r;
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic clr_i,
  output logic run_o
);
  tbc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TBC_STOPPED: if (trig_i)           state_d = TBC_RUNNING;
      TBC_RUNNING: if (clr_i && !trig_i) state_d = TBC_STOPPED;
      default:                           state_d = TBC_STOPPED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TBC_STOPPED;
    else         state_q <= state_d;
  end

  assign run_o = (state_q == TBC_RUNNING);
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_sel_i,
  input  logic             ext_tick_i,
  input  logic             inhibit_ni,
  input  logic [DIV_W-1:0] div_cfg_i,
  output logic             tick_o,
  output logic             mon_o
);
  logic [DIV_W-1:0] div_q;
  logic             int_tick;
  logic             src_tick;

  assign int_tick = (div_q >= div_cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (!run_i)   div_q <= '0;
    else if (int_tick) div_q <= '0;
    else               div_q <= div_q + DIV_W'(1);
  end

  assign src_tick = ext_sel_i ? ext_tick_i : int_tick;
  assign tick_o   = run_i & inhibit_ni & src_tick;
  assign mon_o    = ~(run_i & src_tick);
endmodule

// File: rtl/tbc_counter.sv
module tbc_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] q_o,
  output logic         armed_o
);
  logic [W-1:0] q_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '1;
      armed_q <= 1'b1;
    end else if (!run_i) begin
      q_q     <= '1;
      armed_q <= 1'b1;
    end else if (tick_i) begin
      if (armed_q) begin
        q_q     <= '0;
        armed_q <= 1'b0;
      end else begin
        q_q     <= q_q + W'(1);
      end
    end
  end

  assign q_o     = q_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/tbc_combine.sv
module tbc_combine #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] sel_i,
  output logic         combo_o
);
  logic [W-1:0] line_hi;

  for (genvar i = 0; i < W; i++) begin : g_line
    assign line_hi[i] = q_i[i] | ~sel_i[i];
  end

  assign combo_o = &line_hi;
endmodule

// File: rtl/tbc_delay_timer.sv
module tbc_delay_timer
  import tbc_pkg::*;
#(
  parameter int unsigned CNT_W       = TBC_CNT_W,
  parameter int unsigned DIV_W       = TBC_DIV_W,
  parameter int unsigned SYNC_STAGES = TBC_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             reset_req_i,
  input  logic             tb_ext_sel_i,
  input  logic             ext_tick_i,
  input  logic             inhibit_ni,
  input  logic [DIV_W-1:0] div_cfg_i,
  input  logic [CNT_W-1:0] sel_i,
  output logic [CNT_W-1:0] q_o,
  output logic             tb_mon_o,
  output logic             combo_o
);
  localparam int unsigned CTL_W = 2;

  logic [CTL_W-1:0] ctl_syn;
  logic             trig_s;
  logic             rst_s;
  logic             run;
  logic             eff_tick;
  logic             armed;

  tbc_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({trig_i, reset_req_i}),
    .q_o   (ctl_syn)
  );

  assign trig_s = ctl_syn[1];
  assign rst_s  = ctl_syn[0];

  tbc_ctrl u_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_s),
    .clr_i (rst_s),
    .run_o (run)
  );

  tbc_timebase #(.DIV_W(DIV_W)) u_tbase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .ext_sel_i (tb_ext_sel_i),
    .ext_tick_i(ext_tick_i),
    .inhibit_ni(inhibit_ni),
    .div_cfg_i (div_cfg_i),
    .tick_o    (eff_tick),
    .mon_o     (tb_mon_o)
  );

  tbc_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (eff_tick),
    .q_o    (q_o),
    .armed_o(armed)
  );

  tbc_combine #(.W(CNT_W)) u_comb (
    .q_i    (q_o),
    .sel_i  (sel_i),
    .combo_o(combo_o)
  );
endmodule

// File: rtl/tbc_delay_timer_chk.sv
module tbc_delay_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             armed,
  input logic             eff_tick,
  input logic             trig_s,
  input logic             rst_s,
  input logic             inhibit_ni,
  input logic [CNT_W-1:0] q_o,
  input logic             tb_mon_o
);
  a_r1_stopped_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && $past(!run)) |-> (q_o == {CNT_W{1'b1}}));

  a_r2_trigger_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && trig_s) |=> run);

  a_r3_hold_until_first_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && armed) |-> (q_o == {CNT_W{1'b1}}));

  a_r4_running_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !rst_s) |=> run);

  a_r5_reset_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && rst_s && !trig_s) |=> !run);

  a_r6_trigger_masks_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && trig_s) |=> run);

  a_r7_tick_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !armed && eff_tick) |=> (q_o == CNT_W'($past(q_o) + 1'b1)));

  a_r9_inhibit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !inhibit_ni) |=> $stable(q_o));

  a_r11_monitor_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> tb_mon_o);
endmodule

bind tbc_delay_timer tbc_delay_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run       (run),
  .armed     (armed),
  .eff_tick  (eff_tick),
  .trig_s    (trig_s),
  .rst_s     (rst_s),
  .inhibit_ni(inhibit_ni),
  .q_o       (q_o),
  .tb_mon_o  (tb_mon_o)
);

// File: tb/tbc_delay_timer_tb.sv
module tbc_delay_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, trig, rst_drv, fb_en, ext_sel, ext_tick, inh_n;
  logic [DW-1:0] div_cfg;
  logic [CW-1:0] sel, q;
  logic          mon, combo, rst_req;

  assign rst_req = fb_en ? combo : rst_drv;

  tbc_delay_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .reset_req_i(rst_req),
    .tb_ext_sel_i(ext_sel), .ext_tick_i(ext_tick), .inhibit_ni(inh_n),
    .div_cfg_i(div_cfg), .sel_i(sel), .q_o(q), .tb_mon_o(mon), .combo_o(combo)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic bit f_combo(input int qv, input logic [CW-1:0] s);
    for (int i = 0; i < CW; i++) if (s[i] && !qv[i]) return 1'b0;
    return 1'b1;
  endfunction

  // behavioural reference model
  int m_q = 255;
  int m_div = 0;
  bit m_run = 1'b0;
  bit m_armed = 1'b1;
  bit qt[$] = '{1'b0, 1'b0};
  bit qr[$] = '{1'b0, 1'b0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = 255; m_div = 0; m_run = 1'b0; m_armed = 1'b1;
      qt = '{1'b0, 1'b0};
      qr = '{1'b0, 1'b0};
    end else begin
      bit int_t, src, eff, ts, rs, rin;
      int_t = (m_div >= int'(div_cfg));
      src   = ext_sel ? ext_tick : int_t;
      eff   = m_run && inh_n && src;
      rin   = fb_en ? f_combo(m_q, sel) : rst_drv;
      ts = qt.pop_front();
      rs = qr.pop_front();
      qt.push_back(trig);
      qr.push_back(rin);
      if (!m_run) begin
        m_q = 255; m_armed = 1'b1;
      end else if (eff) begin
        if (m_armed) begin m_q = 0; m_armed = 1'b0; end
        else m_q = (m_q + 1) % 256;
      end
      if (!m_run || int_t) m_div = 0;
      else m_div = m_div + 1;
      if (!m_run && ts) m_run = 1'b1;
      else if (m_run && rs && !ts) m_run = 1'b0;
    end
  end

  always @(negedge clk) begin : cmp
    bit srcn;
    if (rst_n) begin
      srcn = ext_sel ? ext_tick : (m_div >= int'(div_cfg));
      chk(int'(q) == m_q, "R7 count vs model", int'(q), m_q);
      chk(combo == f_combo(m_q, sel), "R8 combined vs model", int'(combo), int'(f_combo(m_q, sel)));
      chk(mon == !(m_run && srcn), "R11 monitor vs model", int'(mon), int'(!(m_run && srcn)));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    int cnt;
    rst_n = 0; trig = 0; rst_drv = 0; fb_en = 0; ext_sel = 0; ext_tick = 0;
    inh_n = 1; div_cfg = '0; sel = '0;
    go(3);
    chk(q == 8'hFF, "R1 reset count", q, 255);
    chk(mon == 1'b1, "R1 reset monitor", mon, 1);
    chk(combo == 1'b1, "R1 reset combined", combo, 1);
    #1 rst_n = 1;
    go(3);
    chk(q == 8'hFF, "R1 idle after reset", q, 255);

    // start with a tick every cycle
    #1 trig = 1;
    go(2); chk(mon == 1'b1, "R2 not yet running", mon, 1);
    go(1); chk(mon == 1'b0, "R2 running at third edge", mon, 0);
    go(1); chk(q == 8'h00, "R3 first tick clears", q, 0);
    go(1); chk(q == 8'h01, "R7 next tick increments", q, 1);

    // trigger activity while running
    #1 trig = 0; go(1);
    #1 trig = 1; go(1);
    #1 trig = 0; go(3);
    chk(q == 8'd6, "R4 trigger ignored while running", q, 6);

    #1 inh_n = 0; go(4);
    chk(q == 8'd6, "R9 inhibit holds count", q, 6);
    #1 inh_n = 1; go(1);
    chk(q == 8'd7, "R9 count resumes", q, 7);

    // reset while trigger high
    #1 trig = 1; go(3);
    chk(q == 8'd10, "R6 still counting", q, 10);
    #1 rst_drv = 1; go(6);
    chk(q == 8'd16, "R6 reset masked by trigger", q, 16);
    #1 trig = 0; go(3);
    chk(q == 8'd19, "R6 counting until stop edge", q, 19);
    go(1);
    chk(q == 8'hFF, "R6 reset acts on trigger fall", q, 255);
    #1 rst_drv = 0;

    // plain reset with trigger low
    #1 trig = 1; go(4);
    chk(q == 8'd0, "R3 cleared after restart", q, 0);
    #1 trig = 0; go(4);
    chk(q == 8'd4, "R7 counting", q, 4);
    #1 rst_drv = 1; go(3);
    chk(q == 8'd7, "R5 counting before stop", q, 7);
    go(1);
    chk(q == 8'hFF, "R5 reset stops block", q, 255);
    chk(mon == 1'b1, "R11 monitor high when stopped", mon, 1);
    #1 rst_drv = 0;

    // internal divider period 4
    #1 div_cfg = 16'd3; trig = 1;
    go(6); chk(q == 8'hFF, "R10 waiting first divided tick", q, 255);
    go(1); chk(q == 8'd0, "R10 first divided tick clears", q, 0);
    go(3); chk(q == 8'd0, "R10 no tick inside period", q, 0);
    go(1); chk(q == 8'd1, "R10 second divided tick", q, 1);
    go(4); chk(q == 8'd2, "R10 third divided tick", q, 2);
    #1 trig = 0; rst_drv = 1; go(5);
    chk(q == 8'hFF, "R5 stop after divider run", q, 255);
    #1 rst_drv = 0;

    // external tick source
    #1 ext_sel = 1; ext_tick = 0; div_cfg = '0; trig = 1;
    go(6); chk(q == 8'hFF, "R10 external source idle", q, 255);
    #1 ext_tick = 1;
    go(1); chk(q == 8'd0, "R10 external first tick", q, 0);
    go(1); chk(q == 8'd1, "R10 external tick counts", q, 1);
    #1 ext_tick = 0; go(3);
    chk(q == 8'd1, "R10 external quiet holds", q, 1);
    #1 ext_tick = 1; go(254);
    chk(q == 8'hFF, "R7 reached maximum", q, 255);
    chk(combo == 1'b1, "R8 empty mask high", combo, 1);
    go(1); chk(q == 8'd0, "R7 wrap to zero", q, 0);
    go(1); chk(q == 8'd1, "R7 continues after wrap", q, 1);
    #1 trig = 0; rst_drv = 1; go(5);
    chk(q == 8'hFF, "R5 stop after wrap", q, 255);
    #1 rst_drv = 0; ext_tick = 0; ext_sel = 0;

    // one-shot with bit 5 fed back, period 2
    #1 div_cfg = 16'd1; sel = 8'h20; fb_en = 1; trig = 1;
    go(5);
    #1 trig = 0;
    cnt = 0;
    while (!combo && cnt < 1000) begin cnt++; go(1); end
    chk(cnt == 64, "R8 one-shot 32 periods", cnt, 64);
    go(6); chk(q == 8'hFF, "R8 one-shot returns to stop", q, 255);

    // one-shot with bits 0,4,5 fed back
    #1 sel = 8'h31; trig = 1;
    go(5);
    #1 trig = 0;
    cnt = 0;
    while (!combo && cnt < 1000) begin cnt++; go(1); end
    chk(cnt == 98, "R8 one-shot 49 periods", cnt, 98);
    go(6); chk(q == 8'hFF, "R8 second one-shot stops", q, 255);
    #1 fb_en = 0; sel = '0;
    go(3);
    finish_run();
  end
endmodule